// File: doc/BRIEF.md
# Power-Down and Reset Clock Sequencer

This block decides, cycle by cycle, which clocks of a small microcontroller are allowed to run. It has four operating states. In run, everything is clocked. In idle, the processor clock is gated off while the peripherals and the main oscillator continue. In stop, the main oscillator and the peripheral clock are also shut off. In settle, the block waits for the main oscillator to stabilize. Instruction decode raises a one-cycle request to enter idle or stop. A pending interrupt or a reset brings the block back out of either power-down state.

A reset does not release the processor immediately. It always forces the settle state, which behaves like idle. A counter then runs for 2^STAB_LOG2 main clock cycles before the processor clock is enabled again. The default of 2^17 cycles is about 31.3 ms at 4.19 MHz. An interrupt that ends stop mode goes through the same settle wait, because the oscillator has to restart. An interrupt that ends idle mode restarts the processor on the next cycle. The enable for the subsystem oscillator follows a configuration input in every state and is never gated by stop. All enables come straight from flip-flops.

Top module: `pwr_clk_seq`

## Requirements
- R1: On any clock edge with `rst` high, the next outputs are `mode`=2'b11 (settle), `cpu_clk_en`=0, `periph_clk_en`=1, `main_osc_en`=1 and `sub_osc_en`=0.
- R2: After `rst` goes low, the block stays in settle for exactly 2^STAB_LOG2 clock edges. `cpu_clk_en` rises on the 2^STAB_LOG2-th edge with `rst` low, and `mode` becomes 2'b00 (run) on that same edge.
- R3: In run (`mode`=2'b00), `cpu_clk_en`, `periph_clk_en` and `main_osc_en` are all 1.
- R4: `idle_req` sampled high in run moves the block to idle (`mode`=2'b01) on that edge, with `cpu_clk_en`=0, `periph_clk_en`=1 and `main_osc_en`=1.
- R5: `stop_req` sampled high in run moves the block to stop (`mode`=2'b10) on that edge, with `cpu_clk_en`, `periph_clk_en` and `main_osc_en` all 0.
- R6: When `idle_req` and `stop_req` are sampled high together in run, the block enters stop.
- R7: `irq_pend` sampled high in idle returns the block to run on that edge.
- R8: `irq_pend` sampled high in stop moves the block to settle (oscillator on, processor off) on that edge. Run follows exactly 2^STAB_LOG2 edges later.
- R9: `idle_req` and `stop_req` are ignored in idle, stop and settle. `irq_pend` is ignored in run and settle.
- R10: A reset taken in run, idle or stop behaves exactly as in R1 and R2.
- R11: On every edge with `rst` low, `sub_osc_en` takes the value of `sub_keep`, whatever the mode.
- R12: `cpu_clk_en` is never 1 while `main_osc_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | 1 | Request to enter idle, from instruction decode |
| stop_req | input | 1 | Request to enter stop, from instruction decode |
| irq_pend | input | 1 | Interrupt pending, wakes from idle or stop |
| sub_keep | input | 1 | Subsystem oscillator wanted |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Subsystem oscillator enable |
| mode | output | 2 | Current state: 00 run, 01 idle, 10 stop, 11 settle |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around the rising edge. They also assume that `rst` is a synchronous level, so that the state seen one edge after an input pattern is fully determined by that pattern and the current mode. The bench meets this by changing every input only on the falling edge. It mixes random request, interrupt and rare reset pulses with directed sequences: simultaneous requests, requests issued during settle, and a reset taken in stop. A shortened stabilization window keeps each settle wait short enough to be crossed many times.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [1:0] {
    PM_RUN    = 2'b00,
    PM_IDLE   = 2'b01,
    PM_STOP   = 2'b10,
    PM_SETTLE = 2'b11
  } pm_mode_t;

  typedef struct packed {
    logic cpu;
    logic periph;
    logic osc;
  } pm_en_t;

  // clock enables implied by each mode
  function automatic pm_en_t en_of(pm_mode_t m);
    pm_en_t e;
    case (m)
      PM_RUN:  e = '{cpu: 1'b1, periph: 1'b1, osc: 1'b1};
      PM_IDLE: e = '{cpu: 1'b0, periph: 1'b1, osc: 1'b1};
      PM_STOP: e = '{cpu: 1'b0, periph: 1'b0, osc: 1'b0};
      default: e = '{cpu: 1'b0, periph: 1'b1, osc: 1'b1};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/pdc_stab_cnt.sv
module pdc_stab_cnt #(
  parameter int STAB_LOG2 = 17
) (
  input  logic clk,
  input  logic clr,
  input  logic inc,
  output logic done
);
  logic [STAB_LOG2-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr)      cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  // last count of the window
  assign done = &cnt_q;
endmodule

// File: rtl/pdc_mode_fsm.sv
module pdc_mode_fsm
  import pdc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     idle_req,
  input  logic     stop_req,
  input  logic     irq_pend,
  input  logic     settle_done,
  output pm_mode_t mode_nx,
  output pm_mode_t mode_q
);
  always_comb begin
    mode_nx = mode_q;
    if (rst) begin
      mode_nx = PM_SETTLE;
    end else begin
      case (mode_q)
        PM_RUN:    if (stop_req) mode_nx = PM_STOP;
                   else if (idle_req) mode_nx = PM_IDLE;
        PM_IDLE:   if (irq_pend) mode_nx = PM_RUN;
        PM_STOP:   if (irq_pend) mode_nx = PM_SETTLE;
        PM_SETTLE: if (settle_done) mode_nx = PM_RUN;
        default:   mode_nx = PM_SETTLE;
      endcase
    end
  end

  always_ff @(posedge clk) mode_q <= mode_nx;

  // R6: stop takes priority over idle
  a_r6_stop_wins: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_RUN && stop_req && idle_req) |=> mode_q == PM_STOP);

  // R9: settle is held until the window ends, whatever the requests
  a_r9_settle_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_SETTLE && !settle_done) |=> mode_q == PM_SETTLE);
endmodule

// File: rtl/pdc_en_reg.sv
module pdc_en_reg
  import pdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pm_mode_t   mode_nx,
  input  logic       sub_keep,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       main_osc_en,
  output logic       sub_osc_en,
  output logic [1:0] mode
);
  pm_en_t en_nx;
  assign en_nx = en_of(mode_nx);

  always_ff @(posedge clk) begin
    cpu_clk_en    <= en_nx.cpu;
    periph_clk_en <= en_nx.periph;
    main_osc_en   <= en_nx.osc;
    mode          <= mode_nx;
    sub_osc_en    <= rst ? 1'b0 : sub_keep;
  end
endmodule

// File: rtl/pwr_clk_seq.sv
module pwr_clk_seq
  import pdc_pkg::*;
#(
  parameter int STAB_LOG2 = 17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       idle_req,
  input  logic       stop_req,
  input  logic       irq_pend,
  input  logic       sub_keep,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       main_osc_en,
  output logic       sub_osc_en,
  output logic [1:0] mode
);
  pm_mode_t mode_nx, mode_q;
  logic     settle_done;
  logic     in_settle;

  assign in_settle = (mode_q == PM_SETTLE);

  pdc_stab_cnt #(.STAB_LOG2(STAB_LOG2)) u_cnt (
    .clk  (clk),
    .clr  (rst | ~in_settle),
    .inc  (in_settle),
    .done (settle_done)
  );

  pdc_mode_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .idle_req    (idle_req),
    .stop_req    (stop_req),
    .irq_pend    (irq_pend),
    .settle_done (settle_done),
    .mode_nx     (mode_nx),
    .mode_q      (mode_q)
  );

  pdc_en_reg u_out (
    .clk           (clk),
    .rst           (rst),
    .mode_nx       (mode_nx),
    .sub_keep      (sub_keep),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .main_osc_en   (main_osc_en),
    .sub_osc_en    (sub_osc_en),
    .mode          (mode)
  );

  // R1 / R10: reset always lands in settle with the processor gated
  a_r1_reset_settle: assert property (@(posedge clk)
    rst |=> (mode == 2'b11 && !cpu_clk_en && main_osc_en));

  // R5: stop shuts every main-domain clock
  a_r5_stop_all_off: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |-> (!cpu_clk_en && !periph_clk_en && !main_osc_en));

  // R7: interrupt ends idle on the next edge
  a_r7_idle_wake: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && irq_pend) |=> (cpu_clk_en && mode == 2'b00));

  // R8: interrupt ends stop through settle
  a_r8_stop_wake: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && irq_pend) |=> (mode == 2'b11 && main_osc_en && !cpu_clk_en));

  // R12: processor clock only with oscillator running
  a_r12_cpu_needs_osc: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> main_osc_en);

  // R11: subsystem oscillator tracks its configuration input
  a_r11_sub_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sub_osc_en == $past(sub_keep)));
endmodule

// File: tb/sim_pwr_clk_seq.sv
`timescale 1ns/1ps
module sim_pwr_clk_seq;
  localparam int STAB_LOG2 = 6;
  localparam int STAB = 1 << STAB_LOG2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic idle_req = 1'b0, stop_req = 1'b0, irq_pend = 1'b0, sub_keep = 1'b0;
  logic cpu_clk_en, periph_clk_en, main_osc_en, sub_osc_en;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;
  bit fin = 0;

  logic [1:0] em = 2'b11;
  int ec = 0;
  logic esub = 1'b0;

  always #10 clk = ~clk;

  pwr_clk_seq #(.STAB_LOG2(STAB_LOG2)) u0 (
    .clk(clk), .rst(rst), .idle_req(idle_req), .stop_req(stop_req),
    .irq_pend(irq_pend), .sub_keep(sub_keep), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .main_osc_en(main_osc_en),
    .sub_osc_en(sub_osc_en), .mode(mode));

  // expected {cpu, periph, osc} from mode encoding
  function automatic logic [2:0] exp_en(input logic [1:0] m);
    case (m)
      2'b00:   return 3'b111;
      2'b01:   return 3'b011;
      2'b10:   return 3'b000;
      default: return 3'b011;
    endcase
  endfunction

  function automatic logic [5:0] exp_vec();
    return {em, exp_en(em), esub};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge: drive, advance model, compare at next falling edge
  task automatic step(input logic iq, input logic sq, input logic ir,
                      input logic rs, input logic sk, input string tag);
    logic [5:0] act;
    idle_req = iq; stop_req = sq; irq_pend = ir; rst = rs; sub_keep = sk;
    if (rs) begin
      em = 2'b11; ec = 0;
    end else begin
      case (em)
        2'b00: if (sq) em = 2'b10; else if (iq) em = 2'b01;
        2'b01: if (ir) em = 2'b00;
        2'b10: if (ir) begin em = 2'b11; ec = 0; end
        default: if (ec == STAB - 1) begin em = 2'b00; ec = 0; end
                 else ec++;
      endcase
    end
    esub = rs ? 1'b0 : sk;
    @(negedge clk);
    act = {mode, cpu_clk_en, periph_clk_en, main_osc_en, sub_osc_en};
    check(act == exp_vec(), tag, act, exp_vec());
    if (cpu_clk_en && !main_osc_en) check(1'b0, "R12", 1, 0);
  endtask

  initial begin
    int n;
    void'($urandom(32'd1234));
    @(negedge clk);
    step(0, 0, 0, 1, 1, "R1");
    step(1, 1, 1, 1, 1, "R1");

    // R2: exact stabilization length after reset release
    n = 0;
    do begin step(0, 0, 0, 0, 1, "R2"); n++; end while (!cpu_clk_en && n < 4 * STAB);
    check(n == STAB, "R2", n, STAB);

    repeat (3) step(0, 0, 0, 0, 1, "R3");
    step(0, 0, 1, 0, 1, "R9");
    step(1, 0, 0, 0, 1, "R4");
    step(0, 0, 0, 0, 1, "R4");
    step(0, 1, 0, 0, 1, "R9");
    check(mode == 2'b01, "R9", mode, 1);
    step(0, 0, 1, 0, 1, "R7");
    check(cpu_clk_en == 1'b1, "R7", cpu_clk_en, 1);

    step(1, 1, 0, 0, 1, "R6");
    check(mode == 2'b10, "R6", mode, 2);
    step(1, 0, 0, 0, 0, "R11");
    check(sub_osc_en == 1'b0, "R11", sub_osc_en, 0);
    step(0, 0, 0, 0, 1, "R11");
    check(sub_osc_en == 1'b1, "R11", sub_osc_en, 1);
    check(main_osc_en == 1'b0, "R5", main_osc_en, 0);

    // R8 wake from stop, with requests pressed during settle (R9)
    step(0, 0, 1, 0, 1, "R8");
    n = 0;
    do begin step(1, 1, 1, 0, 1, "R9"); n++; end while (!cpu_clk_en && n < 4 * STAB);
    check(n == STAB, "R8", n, STAB);

    // R10: reset taken in stop
    step(0, 1, 0, 0, 1, "R5");
    step(0, 0, 0, 1, 1, "R10");
    n = 0;
    do begin step(0, 0, 0, 0, 1, "R10"); n++; end while (!cpu_clk_en && n < 4 * STAB);
    check(n == STAB, "R10", n, STAB);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic iq, sq, ir, rs, sk;
      string tg;
      iq = ($urandom % 100) < 10;
      sq = ($urandom % 100) < 5;
      ir = ($urandom % 100) < 8;
      rs = ($urandom % 1000) < 5;
      sk = ($urandom % 100) < 80;
      case (em)
        2'b00: tg = "R3";
        2'b01: tg = "R4";
        2'b10: tg = "R5";
        default: tg = "R2";
      endcase
      step(iq, sq, ir, rs, sk, tg);
    end

    fin = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule